// File: doc/BRIEF.md
# Host Data-Request Byte Transfer Controller

This block hands a programmed number of bytes from a buffer-side byte stream to a host bus. A control processor sets a 12-bit byte count through an indirect register port and then issues a start. While the transfer is enabled, the block raises a data-request output whenever the buffer stream offers a valid byte. The host answers each request with a one-cycle read strobe. Each accepted strobe returns one byte and pops it from the stream, much as a DMA controller would.

The counter runs down from the loaded value. The byte that makes it wrap is the last one, so a loaded value of N moves N+1 bytes. During the read strobe of that last byte the block drives end-of-process. On the next edge it drops the enable and raises a transfer-complete interrupt. The interrupt stays up until the processor writes an acknowledge. The processor watches progress through an active-low interface status byte and through the live count bytes.

A three-state machine sets the behaviour. In IDLE a start write takes the machine to XFER. In XFER an accepted strobe that finds the count at zero takes it to DONE. In DONE an acknowledge write takes it back to IDLE. No other transition exists.

Top module: `host_drq_xfer`

## Requirements
- R1: After reset the machine is in IDLE. The request, end-of-process, enable and interrupt outputs are low. The interface status byte reads 0xFF.
- R2: A write with register select low loads the 4-bit register index from data bits 3..0. A read with register select low returns that index in bits 3..0, with bits 7..4 reading 0.
- R3: With register select high, index 2 accesses the low count byte (count bits 7..0) and index 3 accesses the high count byte (count bits 11..8 in bits 3..0). A read of index 3 returns the transfer-end flag in bits 7..4: 1 when clear, 0 when set. Indices other than 1, 2 and 3 read 0x00.
- R4: The request output is high exactly when the machine is in XFER and the buffer stream has a valid byte. A strobe given while the stream has no valid byte returns 0xFF, pops nothing and leaves the count unchanged.
- R5: In XFER, a strobe that meets a valid byte returns that byte on the host data output in the same cycle. It asserts the buffer pop and decrements the count by one. Bytes reach the host in stream order.
- R6: End-of-process is high only during the accepted strobe that finds the count at zero.
- R7: After that strobe the machine is in DONE. The enable is low and the interrupt is high. The status byte reads 0xBF, and the count reads 0xFFF (low byte 0xFF, high byte 0x0F).
- R8: The interrupt and the transfer-end flag hold until a write of index 5 with register select high. That write returns the machine to IDLE, and the status byte then reads 0xFF.
- R9: A strobe outside XFER returns 0xFF, pops nothing and leaves the count unchanged.
- R10: The start write (index 5 is acknowledge, index 4 is start) has effect only in IDLE. Count byte writes are ignored outside IDLE.
- R11: A loaded count of zero followed by start moves exactly one byte, and end-of-process is high on that byte.
- R12: Status byte bits, from bit 7 down to bit 0: command interrupt (reads 1), transfer-end flag, decode interrupt (reads 1), constant 1, data busy, status busy (reads 1), enable, status enable (reads 1). Every flag is active-low, so the byte reads 0xF5 in XFER.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 index register, 1 indexed register |
| reg_wr | input | 1 | Processor write strobe, one cycle |
| reg_wdata | input | 8 | Processor write data |
| reg_rdata | output | 8 | Processor read data, combinational |
| buf_data | input | 8 | Byte offered by the buffer stream |
| buf_valid | input | 1 | Buffer byte is valid |
| buf_take | output | 1 | Pop the offered byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_data | output | 8 | Byte returned to the host |
| drq | output | 1 | Data request to the host |
| eop | output | 1 | End of process, during the final read |
| dten | output | 1 | Transfer enabled |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Some rules are checked on every cycle. A request never appears without a valid byte and an enabled transfer. A pop only comes from a strobe that meets a request. End-of-process coincides with a pop and is followed by DONE, and a stray strobe outside XFER returns 0xFF. The interrupt cannot drop without a processor write, and enable and interrupt are never high together. Other behaviour can only be shown by the bench's scenarios. These are the byte order and values the host receives, the exact strobe count before the wrap, the readback values of the registers, and start and count writes being ignored outside IDLE.

// File: rtl/host_drq_pkg.sv
package host_drq_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 12;
    localparam int IDX_W  = 4;

    localparam int IDX_STAT  = 1;
    localparam int IDX_CNTL  = 2;
    localparam int IDX_CNTH  = 3;
    localparam int IDX_START = 4;
    localparam int IDX_ACK   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/host_drq_regs.sv
module host_drq_regs
    import host_drq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          in_idle,
    input  logic          accept,
    input  logic          dten,
    input  logic          irq,
    output logic          start_req,
    output logic          ack_req,
    output logic          cnt_zero
);
    localparam int HW = CW - DW;

    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic          sel_wr;
    logic [DW-1:0] status;

    assign sel_wr    = reg_wr & reg_sel;
    assign start_req = sel_wr && (idx_q == IW'(IDX_START));
    assign ack_req   = sel_wr && (idx_q == IW'(IDX_ACK));
    assign cnt_zero  = (cnt_q == '0);

    // Active-low flag byte; unused flags read inactive.
    assign status = {1'b1, ~irq, 1'b1, 1'b1, ~dten, 1'b1, ~dten, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            if (reg_wr && !reg_sel) begin
                idx_q <= reg_wdata[IW-1:0];
            end
            if (accept) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (sel_wr && in_idle) begin
                if (idx_q == IW'(IDX_CNTL)) begin
                    cnt_q[DW-1:0] <= reg_wdata;
                end
                if (idx_q == IW'(IDX_CNTH)) begin
                    cnt_q[CW-1:DW] <= reg_wdata[HW-1:0];
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata = DW'(idx_q);
        end else begin
            case (idx_q)
                IW'(IDX_STAT): reg_rdata = status;
                IW'(IDX_CNTL): reg_rdata = cnt_q[DW-1:0];
                IW'(IDX_CNTH): reg_rdata = {{(DW-HW){~irq}}, cnt_q[CW-1:DW]};
                default:       reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/host_drq_fsm.sv
module host_drq_fsm
    import host_drq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic ack_req,
    input  logic accept,
    input  logic cnt_zero,
    output logic dten,
    output logic irq,
    output logic in_idle
);
    xfer_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req)           state_d = ST_XFER;
            ST_XFER: if (accept && cnt_zero)  state_d = ST_DONE;
            ST_DONE: if (ack_req)             state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        dten    = 1'b0;
        irq     = 1'b0;
        in_idle = 1'b0;
        unique case (state_q)
            ST_IDLE: in_idle = 1'b1;
            ST_XFER: dten    = 1'b1;
            ST_DONE: irq     = 1'b1;
            default: in_idle = 1'b0;
        endcase
    end
endmodule

// File: rtl/host_drq_xfer.sv
module host_drq_xfer
    import host_drq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  buf_data,
    input  logic        buf_valid,
    output logic        buf_take,
    input  logic        host_rd,
    output logic [7:0]  host_data,
    output logic        drq,
    output logic        eop,
    output logic        dten,
    output logic        irq
);
    logic start_req, ack_req, cnt_zero, in_idle, accept;

    assign drq       = dten & buf_valid;
    assign accept    = drq & host_rd;
    assign buf_take  = accept;
    assign host_data = accept ? buf_data : 8'hFF;
    assign eop       = accept & cnt_zero;

    host_drq_regs #(.DW(DATA_W), .CW(CNT_W), .IW(IDX_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_idle   (in_idle),
        .accept    (accept),
        .dten      (dten),
        .irq       (irq),
        .start_req (start_req),
        .ack_req   (ack_req),
        .cnt_zero  (cnt_zero)
    );

    host_drq_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .ack_req   (ack_req),
        .accept    (accept),
        .cnt_zero  (cnt_zero),
        .dten      (dten),
        .irq       (irq),
        .in_idle   (in_idle)
    );
endmodule

// File: rtl/host_drq_chk.sv
module host_drq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic       buf_valid,
    input logic       buf_take,
    input logic       host_rd,
    input logic [7:0] host_data,
    input logic       drq,
    input logic       eop,
    input logic       dten,
    input logic       irq
);
    p_drq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> (buf_valid && dten));

    p_take_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_take |-> (host_rd && drq));

    p_eop_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> buf_take);

    p_eop_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> (!dten && irq));

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dten && irq));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel)) |=> irq);

    p_stray_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !dten) |-> (host_data == 8'hFF && !buf_take));
endmodule

bind host_drq_xfer host_drq_chk i_chk (.*);

// File: tb/test_host_drq_xfer.sv
module test_host_drq_xfer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] buf_data;
    logic       buf_valid = 1'b0;
    logic       buf_take, host_rd = 1'b0;
    logic [7:0] host_data;
    logic       drq, eop, dten, irq;

    int n_cmp = 0, n_bad = 0, ptr = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    logic [7:0] v;

    host_drq_xfer i_host_drq_xfer (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(int p);
        return 8'hA5 ^ 8'(p * 7);
    endfunction

    assign buf_data = pat(ptr);
    always @(posedge clk) if (buf_take) ptr <= ptr + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every popped byte is compared with the scoreboard head.
    always @(negedge clk) begin
        #1;
        if (host_rd && buf_take) begin
            if (exp_q.size() == 0) chk("R5 unexpected pop", 1, 0);
            else chk("R5 byte order", host_data, exp_q.pop_front());
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_wr = 1'b0;
        #2 d = reg_rdata;
    endtask

    task automatic rreg(input logic [3:0] idx, output logic [7:0] d);
        wr(1'b0, {4'h0, idx});
        rd(1'b1, d);
    endtask

    // Driver: one host strobe; pushes the expected byte when it should be taken.
    task automatic hread(string req, input bit acc, input bit last);
        @(negedge clk);
        if (acc) exp_q.push_back(pat(ptr));
        host_rd = 1'b1;
        #2;
        chk({req, " pop"}, buf_take, acc);
        chk({req, " eop"}, eop, last);
        if (!acc) chk({req, " idle data"}, host_data, 8'hFF);
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1 drq", drq, 0); chk("R1 eop", eop, 0);
        chk("R1 dten", dten, 0); chk("R1 irq", irq, 0);
        rreg(4'd1, v); chk("R1 status", v, 8'hFF);

        wr(1'b0, 8'hF3); rd(1'b0, v); chk("R2 index readback", v, 8'h03);
        rreg(4'd0, v); chk("R3 unused index", v, 8'h00);

        wr(1'b0, 8'd2); wr(1'b1, 8'h04);
        wr(1'b0, 8'd3); wr(1'b1, 8'h5A);
        rreg(4'd2, v); chk("R3 count low", v, 8'h04);
        rreg(4'd3, v); chk("R3 count high", v, 8'hFA);
        wr(1'b0, 8'd3); wr(1'b1, 8'h00);
        rreg(4'd3, v); chk("R3 count high cleared", v, 8'hF0);

        buf_valid = 1'b1;
        hread("R9 strobe idle", 0, 0);
        rreg(4'd2, v); chk("R9 count kept", v, 8'h04);

        wr(1'b0, 8'd4); wr(1'b1, 8'h00);
        rd(1'b1, v);
        chk("R12 status xfer", 8'h00 | 0, 0);
        rreg(4'd1, v); chk("R12 status xfer", v, 8'hF5);
        chk("R4 drq valid", drq, 1);
        @(negedge clk); buf_valid = 1'b0; #2 chk("R4 drq withheld", drq, 0);
        hread("R4 strobe no data", 0, 0);
        rreg(4'd2, v); chk("R4 count kept", v, 8'h04);
        buf_valid = 1'b1;

        wr(1'b1, 8'h77);
        rreg(4'd2, v); chk("R10 count write ignored", v, 8'h04);

        hread("R5 byte 0", 1, 0);
        hread("R5 byte 1", 1, 0);
        rreg(4'd2, v); chk("R5 decrement", v, 8'h02);
        hread("R6 byte 2", 1, 0);
        hread("R6 byte 3", 1, 0);
        hread("R6 final byte", 1, 1);
        @(negedge clk); #2;
        chk("R7 dten", dten, 0); chk("R7 irq", irq, 1); chk("R7 drq", drq, 0);
        rreg(4'd1, v); chk("R7 status", v, 8'hBF);
        rreg(4'd2, v); chk("R7 count low", v, 8'hFF);
        rreg(4'd3, v); chk("R7 count high", v, 8'h0F);
        hread("R9 strobe done", 0, 0);

        wr(1'b0, 8'd4); wr(1'b1, 8'h00);
        @(negedge clk); #2;
        chk("R10 start in done dten", dten, 0);
        chk("R8 irq held", irq, 1);

        wr(1'b0, 8'd5); wr(1'b1, 8'h00);
        @(negedge clk); #2; chk("R8 irq cleared", irq, 0);
        rreg(4'd1, v); chk("R8 status", v, 8'hFF);
        rreg(4'd3, v); chk("R8 high flag clear", v, 8'hFF);

        wr(1'b0, 8'd2); wr(1'b1, 8'h00);
        wr(1'b0, 8'd3); wr(1'b1, 8'h00);
        wr(1'b0, 8'd4); wr(1'b1, 8'h00);
        hread("R11 single byte", 1, 1);
        @(negedge clk); #2;
        chk("R11 irq", irq, 1); chk("R11 dten", dten, 0);
        hread("R11 no second byte", 0, 0);
        chk("R5 scoreboard empty", exp_q.size(), 0);

        summary();
    end
endmodule